// File: doc/BRIEF.md
# I2C byte-phase interrupt flag and SCL hold controller

This block belongs to a multi-master I2C controller. It keeps an active-low pending flag that drops at the end of every byte phase: a master address byte sent, a data byte sent, a data byte received, or a slave address accepted. While the flag is low the block asks the bus driver to hold SCL low, which stretches the clock until software services the byte. Software releases the flag by writing the data register. It can also release the flag by writing the control register, but only after an early wait interrupt.

Data reception can be reported at the falling edge of the 8th clock or at the falling edge of the ACK clock. An optional wait interrupt reports at the 8th clock even when ACK-clock mode is on. A built-in matcher compares a received slave address against up to three stored 7-bit addresses and recognises the general call. In free data format the first byte is accepted with no comparison. After arbitration is lost, SCL is released unless this device turns out to be the one addressed. A bus-busy flag follows START and STOP conditions seen on synchronised copies of SCL and SDA.

Top module: `i2c_byte_flag_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pend_n`=1, `irq`=0, `scl_hold`=0 and `bus_busy`=0.
- R2: A one-cycle `ev_addr_sent` or `ev_tx_done` pulse sets `pend_n` to 0 at the next clock edge. This holds whatever the value of `arb_lost`.
- R3: When `addr_phase`=0 and `ack_clk_mode`=0, `ev_rx8` drops the flag and `ev_rx9` is ignored. When `ack_clk_mode`=1, `ev_rx9` drops the flag and `ev_rx8` is ignored, unless R4 applies.
- R4: When `wait_int_en`=1, an `ev_rx8` with `addr_phase`=0 drops the flag in either ACK-clock mode and sets an internal wait flag. A `wr_ctrl` strobe while that wait flag and `wait_int_en` are both 1 sets `pend_n` to 1 and clears the wait flag.
- R5: Consider a received byte completing (R3 timing) with `slave_rx`=1, `addr_phase`=1 and `free_format`=0. With `multi_addr_en`=0, the flag drops only if `rx_addr` equals `own_addr0`. With `multi_addr_en`=1, a match with `own_addr0`, `own_addr1` or `own_addr2` drops it. A non-matching address leaves the flag at 1.
- R6: Under the conditions of R5, `rx_addr`=0000000 (general call) drops the flag. With `free_format`=1, any address byte drops the flag.
- R7: A `wr_data` strobe sets `pend_n` to 1. A `wr_ctrl` strobe while the wait flag is clear has no effect on the flag.
- R8: `en`=0 or `soft_rst`=1 forces `pend_n` to 1, `bus_busy` to 0 and `irq` to 0 at the next edge. This overrides any byte event in the same cycle.
- R9: When a byte event and a `wr_data` or `wr_ctrl` strobe fall in the same cycle, the flag goes to 0.
- R10: `scl_hold` is 1 exactly while `pend_n` is 0, with one exception. The hold is suppressed when the flag was dropped by `ev_addr_sent` or `ev_tx_done` with `arb_lost`=1, `free_format`=0, and an `rx_addr` that is neither 0000000 nor any of the three stored addresses. The three stored addresses count here regardless of `multi_addr_en`.
- R11: With `en`=1, SDA falling while SCL is high (START) sets `bus_busy`, and SDA rising while SCL is high (STOP) clears it. Both are judged on 2-flop synchronised copies of the lines. An SDA change while SCL is low has no effect.
- R12: `irq` is 1 for exactly one cycle, in the same cycle that a byte event first drives `pend_n` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable level |
| soft_rst | input | 1 | Interface reset bit |
| ack_clk_mode | input | 1 | 1: data reception reported at ACK clock |
| wait_int_en | input | 1 | Early interrupt at the 8th clock |
| multi_addr_en | input | 1 | Compare all three stored addresses |
| free_format | input | 1 | Accept the first byte with no address compare |
| own_addr0 | input | 7 | First stored slave address |
| own_addr1 | input | 7 | Second stored slave address |
| own_addr2 | input | 7 | Third stored slave address |
| slave_rx | input | 1 | Slave receive mode |
| addr_phase | input | 1 | Current received byte is the address byte |
| arb_lost | input | 1 | Arbitration lost during the current byte |
| rx_addr | input | 7 | Upper seven bits of the received byte |
| ev_addr_sent | input | 1 | Master address byte transmitted (strobe) |
| ev_tx_done | input | 1 | Data byte transmitted (strobe) |
| ev_rx8 | input | 1 | Falling edge of 8th SCL during reception (strobe) |
| ev_rx9 | input | 1 | Falling edge of ACK SCL during reception (strobe) |
| wr_data | input | 1 | Data register write (strobe) |
| wr_ctrl | input | 1 | Control register write (strobe) |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| pend_n | output | 1 | Active-low pending interrupt flag |
| irq | output | 1 | Interrupt request pulse |
| scl_hold | output | 1 | Request to drive SCL low |
| bus_busy | output | 1 | Bus busy flag |

## Verification
Two functions can meet in one cycle. The first pair is a byte event and a register write that would release the flag. The bench drives `ev_tx_done` together with `wr_data`, and later together with `wr_ctrl`, and expects the flag to stay at 0. The second pair is a byte event and a disable or interface reset. The bench drives `ev_tx_done` in the same cycle that `en` falls or `soft_rst` rises, and expects the flag at 1 with no `irq` pulse. A START followed by a disable is also provoked, and `bus_busy` must end at 0.

// File: rtl/i2c_byte_flag_ctl.sv
module i2c_byte_flag_ctl #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          soft_rst,
  input  logic          ack_clk_mode,
  input  logic          wait_int_en,
  input  logic          multi_addr_en,
  input  logic          free_format,
  input  logic [AW-1:0] own_addr0,
  input  logic [AW-1:0] own_addr1,
  input  logic [AW-1:0] own_addr2,
  input  logic          slave_rx,
  input  logic          addr_phase,
  input  logic          arb_lost,
  input  logic [AW-1:0] rx_addr,
  input  logic          ev_addr_sent,
  input  logic          ev_tx_done,
  input  logic          ev_rx8,
  input  logic          ev_rx9,
  input  logic          wr_data,
  input  logic          wr_ctrl,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          pend_n,
  output logic          irq,
  output logic          scl_hold,
  output logic          bus_busy
);

  logic off;
  assign off = !en || soft_rst;

  logic hit0, hit1, hit2, gcall, hit_sel, hit_any;
  assign hit0    = rx_addr == own_addr0;
  assign hit1    = rx_addr == own_addr1;
  assign hit2    = rx_addr == own_addr2;
  assign gcall   = rx_addr == '0;
  assign hit_sel = hit0 || (multi_addr_en && (hit1 || hit2));
  assign hit_any = hit0 || hit1 || hit2 || gcall;

  logic rx_done, data_rx, wait_ev, addr_ok, tx_ev, fall;
  assign rx_done = ack_clk_mode ? ev_rx9 : ev_rx8;
  assign data_rx = rx_done && !addr_phase;
  assign wait_ev = wait_int_en && ev_rx8 && !addr_phase;
  assign addr_ok = slave_rx && addr_phase && rx_done &&
                   (free_format || hit_sel || gcall);
  assign tx_ev   = ev_addr_sent || ev_tx_done;
  assign fall    = tx_ev || data_rx || wait_ev || addr_ok;

  logic wait_flg, no_hold, release_wr, lost_nomatch;
  assign release_wr   = wr_data || (wr_ctrl && wait_int_en && wait_flg);
  assign lost_nomatch = tx_ev && arb_lost && !free_format && !hit_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_n   <= 1'b1;
      irq      <= 1'b0;
      wait_flg <= 1'b0;
      no_hold  <= 1'b0;
    end else if (off) begin
      pend_n   <= 1'b1;
      irq      <= 1'b0;
      wait_flg <= 1'b0;
      no_hold  <= 1'b0;
    end else begin
      irq <= fall;
      if (fall) begin
        pend_n  <= 1'b0;
        no_hold <= lost_nomatch;
        if (wait_ev) wait_flg <= 1'b1;
      end else if (release_wr) begin
        pend_n  <= 1'b1;
        no_hold <= 1'b0;
        if (wr_ctrl) wait_flg <= 1'b0;
      end
    end
  end

  assign scl_hold = !pend_n && !no_hold;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign start_c = scl_sync[1] && scl_q && sda_q && !sda_sync[1];
  assign stop_c  = scl_sync[1] && scl_q && !sda_q && sda_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_busy <= 1'b0;
    else if (off)     bus_busy <= 1'b0;
    else if (start_c) bus_busy <= 1'b1;
    else if (stop_c)  bus_busy <= 1'b0;
  end

endmodule

module i2c_byte_flag_ctl_props (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic soft_rst,
  input logic pend_n,
  input logic irq,
  input logic scl_hold,
  input logic bus_busy
);

  a_r12_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !pend_n);

  a_r12_fall_gives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_n) |-> irq);

  a_r10_hold_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !pend_n);

  a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || soft_rst) |=> (pend_n && !bus_busy && !irq));

  a_r11_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(en));

endmodule

bind i2c_byte_flag_ctl i2c_byte_flag_ctl_props u_props (
  .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst),
  .pend_n(pend_n), .irq(irq), .scl_hold(scl_hold), .bus_busy(bus_busy)
);

// File: tb/i2c_byte_flag_ctl_test.sv
module i2c_byte_flag_ctl_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, soft_rst, ack_clk_mode, wait_int_en, multi_addr_en, free_format;
  logic [6:0] own_addr0, own_addr1, own_addr2, rx_addr;
  logic slave_rx, addr_phase, arb_lost;
  logic ev_addr_sent, ev_tx_done, ev_rx8, ev_rx9, wr_data, wr_ctrl, scl_in, sda_in;
  logic pend_n, irq, scl_hold, bus_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  i2c_byte_flag_ctl uut (.*);

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ev_addr_sent = 0; ev_tx_done = 0; ev_rx8 = 0; ev_rx9 = 0;
    wr_data = 0; wr_ctrl = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // flags {ack,wie,multi,free,srx,aph,arb} events {as,tx,r8,r9} addr exp_pend exp_hold req
  localparam logic [24:0] VEC [17] = '{
    {7'b0000000, 4'b1000, 7'h33, 1'b0, 1'b1, 5'd2},   // R2 address sent
    {7'b0000000, 4'b0100, 7'h33, 1'b0, 1'b1, 5'd2},   // R2 data sent
    {7'b0000000, 4'b0010, 7'h33, 1'b0, 1'b1, 5'd3},   // R3 8th clock
    {7'b0000000, 4'b0001, 7'h33, 1'b1, 1'b0, 5'd3},   // R3 ACK ignored
    {7'b1000000, 4'b0001, 7'h33, 1'b0, 1'b1, 5'd3},   // R3 ACK clock
    {7'b1000000, 4'b0010, 7'h33, 1'b1, 1'b0, 5'd3},   // R3 8th ignored
    {7'b0000110, 4'b0010, 7'h50, 1'b0, 1'b1, 5'd5},   // R5 addr0
    {7'b0000110, 4'b0010, 7'h21, 1'b1, 1'b0, 5'd5},   // R5 addr1 single
    {7'b0010110, 4'b0010, 7'h21, 1'b0, 1'b1, 5'd5},   // R5 addr1 multi
    {7'b0010110, 4'b0010, 7'h6A, 1'b0, 1'b1, 5'd5},   // R5 addr2 multi
    {7'b0000110, 4'b0010, 7'h00, 1'b0, 1'b1, 5'd6},   // R6 general call
    {7'b0001110, 4'b0010, 7'h33, 1'b0, 1'b1, 5'd6},   // R6 free format
    {7'b0000110, 4'b0010, 7'h33, 1'b1, 1'b0, 5'd5},   // R5 no match
    {7'b0000001, 4'b0100, 7'h33, 1'b0, 1'b0, 5'd10},  // R10 lost, not addressed
    {7'b0000001, 4'b0100, 7'h6A, 1'b0, 1'b1, 5'd10},  // R10 lost, addr2
    {7'b0000001, 4'b1000, 7'h00, 1'b0, 1'b1, 5'd10},  // R10 lost, general call
    {7'b0001001, 4'b0100, 7'h33, 1'b0, 1'b1, 5'd10}   // R10 lost, free format
  };

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; en = 1; soft_rst = 0; ack_clk_mode = 0; wait_int_en = 0;
    multi_addr_en = 0; free_format = 0; slave_rx = 0; addr_phase = 0; arb_lost = 0;
    own_addr0 = 7'h50; own_addr1 = 7'h21; own_addr2 = 7'h6A; rx_addr = 7'h33;
    scl_in = 1; sda_in = 1;
    idle();
    step(); step();
    chk("R1", "pend_n in reset", pend_n, 1'b1);
    rst_n = 1;
    step(); step();
    chk("R1", "pend_n", pend_n, 1'b1);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "scl_hold", scl_hold, 1'b0);
    chk("R1", "bus_busy", bus_busy, 1'b0);

    foreach (VEC[i]) begin
      automatic logic [24:0] v = VEC[i];
      automatic string rq = $sformatf("R%0d vec%0d", v[4:0], i);
      {ack_clk_mode, wait_int_en, multi_addr_en, free_format, slave_rx, addr_phase, arb_lost} = v[24:18];
      {ev_addr_sent, ev_tx_done, ev_rx8, ev_rx9} = v[17:14];
      rx_addr = v[13:7];
      step();
      idle();
      chk(rq, "pend_n", pend_n, v[6]);
      chk(rq, "scl_hold", scl_hold, v[5]);
      chk(rq, "irq", irq, ~v[6]);
      wr_data = 1;
      step();
      idle();
      chk("R7", "pend_n after data write", pend_n, 1'b1);
      chk("R10", "scl_hold after release", scl_hold, 1'b0);
    end
    ack_clk_mode = 0; wait_int_en = 0; multi_addr_en = 0; free_format = 0;
    slave_rx = 0; addr_phase = 0; arb_lost = 0; rx_addr = 7'h33;

    // R12: single-cycle pulse
    ev_tx_done = 1; step(); idle();
    chk("R12", "irq first cycle", irq, 1'b1);
    step();
    chk("R12", "irq second cycle", irq, 1'b0);
    chk("R12", "pend_n held", pend_n, 1'b0);
    // R7: control write with no wait flag ignored
    wr_ctrl = 1; step(); idle();
    chk("R7", "pend_n after ctrl write", pend_n, 1'b0);
    wr_data = 1; step(); idle();

    // R4: wait interrupt at 8th clock in ACK mode, released by ctrl write
    ack_clk_mode = 1; wait_int_en = 1;
    ev_rx8 = 1; step(); idle();
    chk("R4", "pend_n wait int", pend_n, 1'b0);
    wr_ctrl = 1; step(); idle();
    chk("R4", "pend_n ctrl release", pend_n, 1'b1);
    ev_tx_done = 1; step(); idle();
    wr_ctrl = 1; step(); idle();
    chk("R4", "wait flag cleared", pend_n, 1'b0);
    wr_data = 1; step(); idle();
    ack_clk_mode = 0; wait_int_en = 0;

    // R9: event beats writes
    ev_tx_done = 1; wr_data = 1; step(); idle();
    chk("R9", "pend_n event+data write", pend_n, 1'b0);
    wait_int_en = 1; ev_rx8 = 1; step(); idle();
    ev_tx_done = 1; wr_ctrl = 1; step(); idle();
    chk("R9", "pend_n event+ctrl write", pend_n, 1'b0);
    wr_data = 1; step(); idle();
    wait_int_en = 0;

    // R8: disable / reset beat events
    ev_tx_done = 1; en = 0; step(); idle();
    chk("R8", "pend_n disable", pend_n, 1'b1);
    chk("R8", "irq disable", irq, 1'b0);
    en = 1;
    ev_tx_done = 1; step(); idle();
    ev_tx_done = 1; soft_rst = 1; step(); idle();
    chk("R8", "pend_n soft reset", pend_n, 1'b1);
    soft_rst = 0; step();

    // R11: START / STOP
    sda_in = 0; repeat (5) step();
    chk("R11", "busy after START", bus_busy, 1'b1);
    sda_in = 1; repeat (5) step();
    chk("R11", "idle after STOP", bus_busy, 1'b0);
    scl_in = 0; repeat (3) step();
    sda_in = 0; repeat (3) step();
    scl_in = 1; repeat (5) step();
    chk("R11", "SDA change with SCL low", bus_busy, 1'b0);
    sda_in = 1; repeat (3) step();
    sda_in = 0; repeat (5) step();
    chk("R11", "busy after second START", bus_busy, 1'b1);
    en = 0; step();
    chk("R8", "busy cleared by disable", bus_busy, 1'b0);
    en = 1; sda_in = 1; repeat (5) step();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule